// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block is the digital decision logic that picks the source feeding a protected RAM rail: the regulated main supply or a backup cell. It receives three comparator flags from the analog front end (main supply under the reset threshold, main supply under the backup voltage, and main supply far under the backup voltage). It drives two path-switch enables and a backup-mode indication. While in backup mode it also forces the levels that the rest of the supervisor presents: the power-fail output, the reset output, and the disables for the watchdog and power-fail input.

Entry into backup needs both the threshold flag and the backup-comparison flag at once. The way back depends on the threshold flag alone. Every flag first passes through a synchronizer and then through a stability filter, so a flag must hold a programmable number of cycles before it counts. A change of path always crosses one cycle with both switches open. When the supply collapses far below the backup cell, the controller signals a shutdown of the auxiliary comparators to save current.

Top module: `bkup_sw_ctrl`

## Requirements
- R1: After reset the main path enable is 1. The backup path enable, backup mode and comparator shutdown are 0.
- R2: The backup path enable goes to 1 only after both the filtered threshold flag (`vcc_lo_thr_i`) and the filtered backup-comparison flag (`vcc_lo_bak_i`) have been 1 together.
- R3: While the backup-comparison flag is 0, the rail stays on the main path even if the threshold flag is 1. A grounded or absent backup source shows up as this case.
- R4: In backup mode, a filtered threshold flag of 0 returns the rail to the main path whatever the backup-comparison flag reads. A backup-comparison flag that falls while the threshold flag stays 1 keeps backup mode.
- R5: Each change between the two paths holds exactly one cycle with both enables at 0.
- R6: The main and backup path enables are never 1 in the same cycle.
- R7: In backup mode the power-fail output (`pfail_n_o`, active low) is 0 and reset is asserted. With the default active-low polarity, `rst_o` is 0. The watchdog and power-fail input disables are 1.
- R8: Outside backup mode, `pfail_n_o` follows `pfail_raw_n_i`, reset follows `rst_req_i` in the configured polarity, and both disables are 0.
- R9: In backup mode a filtered deep-drop flag sets `cmp_off_o` to 1. The output returns to 0 when the flag clears or when backup mode ends.
- R10: A deep-drop flag seen while on the main path has no effect: `cmp_off_o` stays 0.
- R11: A flag change that lasts fewer than `STABLE_CYC` consecutive synchronized cycles is ignored.
- R12: During comparator shutdown, changes of the backup-comparison flag are ignored and backup mode holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| vcc_lo_thr_i | input | 1 | Main supply is under the reset threshold |
| vcc_lo_bak_i | input | 1 | Main supply is under the backup voltage |
| vcc_deep_i | input | 1 | Main supply is far under the backup voltage |
| pfail_raw_n_i | input | 1 | Power-fail comparator result, active low |
| rst_req_i | input | 1 | Reset request from the reset generator, active high |
| main_sw_en_o | output | 1 | Closes the main-supply path switch |
| bak_sw_en_o | output | 1 | Closes the backup path switch |
| bkup_mode_o | output | 1 | Rail is fed from the backup source |
| cmp_off_o | output | 1 | Shut off the auxiliary comparators |
| pfail_n_o | output | 1 | Power-fail output after forcing, active low |
| rst_o | output | 1 | Reset output after forcing, polarity set by `RST_ACT_HIGH` |
| wdog_dis_o | output | 1 | Disables the watchdog |
| pfi_dis_o | output | 1 | Disables the power-fail input |

## Verification
A wrong state register shows up at once on the decoded path enables. An entry taken too early, or a dead cycle that was skipped, appears on the first edge after a filtered flag settles, which is `SYNC_STAGES + STABLE_CYC` cycles after the raw change. A filter counter that clears or saturates wrongly moves that edge by one or more cycles. A cycle-exact model compared on every clock catches that offset. A lost shutdown state shows up on `cmp_off_o`, and wrong forcing shows up on the power-fail and reset outputs in the same cycle as the mode change.

// File: rtl/bkup_sw_pkg.sv
package bkup_sw_pkg;

   localparam int NFLAG    = 3;
   localparam int IDX_THR  = 0;
   localparam int IDX_BAK  = 1;
   localparam int IDX_DEEP = 2;

   typedef enum logic [2:0] {
      ST_MAIN     = 3'd0,
      ST_GAP_BAK  = 3'd1,
      ST_BAK      = 3'd2,
      ST_DEEP     = 3'd3,
      ST_GAP_MAIN = 3'd4
   } sw_state_e;

   typedef struct packed {
      logic main_en;
      logic bak_en;
      logic bkup;
      logic deep;
   } sw_dec_t;

endpackage

// File: rtl/bkup_flag_sync.sv
module bkup_flag_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("bkup_flag_sync: WIDTH must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("bkup_flag_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
               chain_q[s] <= chain_q[s-1];
            end
         end
      end

      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/bkup_flag_filter.sv
module bkup_flag_filter #(
   parameter int STABLE_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);

   if (STABLE_CYC < 1) begin : g_bad_stable
      $error("bkup_flag_filter: STABLE_CYC must be at least 1");
   end

   localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYC - 1);

   logic filt_q;

   if (STABLE_CYC == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) filt_q <= 1'b0;
         else        filt_q <= raw_i;
      end
   end else begin : g_count
      logic [CW-1:0] run_q;
      logic          differs;

      assign differs = (raw_i != filt_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q  <= '0;
            filt_q <= 1'b0;
         end else if (!differs) begin
            run_q  <= '0;
         end else if (run_q == CNT_LAST) begin
            run_q  <= '0;
            filt_q <= raw_i;
         end else begin
            run_q  <= run_q + 1'b1;
         end
      end
   end

   assign filt_o = filt_q;

endmodule

// File: rtl/bkup_sw_fsm.sv
module bkup_sw_fsm
   import bkup_sw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] flt_i,
   output sw_dec_t          dec_o
);

   sw_state_e st_q, st_d;
   logic      lo_thr, lo_bak, deep;

   assign lo_thr = flt_i[IDX_THR];
   assign lo_bak = flt_i[IDX_BAK];
   assign deep   = flt_i[IDX_DEEP];

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_MAIN: begin
            if (lo_thr && lo_bak) st_d = ST_GAP_BAK;
         end
         ST_GAP_BAK: begin
            if (lo_thr && lo_bak) st_d = ST_BAK;
            else                  st_d = ST_MAIN;
         end
         ST_BAK: begin
            if (!lo_thr)   st_d = ST_GAP_MAIN;
            else if (deep) st_d = ST_DEEP;
         end
         ST_DEEP: begin
            if (!lo_thr)    st_d = ST_GAP_MAIN;
            else if (!deep) st_d = ST_BAK;
         end
         ST_GAP_MAIN: begin
            st_d = ST_MAIN;
         end
         default: st_d = ST_MAIN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_MAIN;
      else        st_q <= st_d;
   end

   always_comb begin
      dec_o.main_en = (st_q == ST_MAIN);
      dec_o.bak_en  = (st_q == ST_BAK) || (st_q == ST_DEEP);
      dec_o.bkup    = (st_q == ST_BAK) || (st_q == ST_DEEP);
      dec_o.deep    = (st_q == ST_DEEP);
   end

endmodule

// File: rtl/bkup_out_force.sv
module bkup_out_force #(
   parameter bit RST_ACT_HIGH = 1'b0
) (
   input  logic bkup_i,
   input  logic pfail_raw_n_i,
   input  logic rst_req_i,
   output logic pfail_n_o,
   output logic rst_o,
   output logic wdog_dis_o,
   output logic pfi_dis_o
);

   logic rst_act;

   assign rst_act    = bkup_i | rst_req_i;
   assign pfail_n_o  = pfail_raw_n_i & ~bkup_i;
   assign wdog_dis_o = bkup_i;
   assign pfi_dis_o  = bkup_i;

   if (RST_ACT_HIGH) begin : g_rst_hi
      assign rst_o = rst_act;
   end else begin : g_rst_lo
      assign rst_o = ~rst_act;
   end

endmodule

// File: rtl/bkup_sw_ctrl.sv
module bkup_sw_ctrl
   import bkup_sw_pkg::*;
#(
   parameter int STABLE_CYC   = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit RST_ACT_HIGH = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vcc_lo_thr_i,
   input  logic vcc_lo_bak_i,
   input  logic vcc_deep_i,
   input  logic pfail_raw_n_i,
   input  logic rst_req_i,
   output logic main_sw_en_o,
   output logic bak_sw_en_o,
   output logic bkup_mode_o,
   output logic cmp_off_o,
   output logic pfail_n_o,
   output logic rst_o,
   output logic wdog_dis_o,
   output logic pfi_dis_o
);

   if (STABLE_CYC < 1) begin : g_bad_stable
      $error("bkup_sw_ctrl: STABLE_CYC must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("bkup_sw_ctrl: SYNC_STAGES must not be negative");
   end

   logic [NFLAG-1:0] raw_flags;
   logic [NFLAG-1:0] sync_flags;
   logic [NFLAG-1:0] flt_q;
   sw_dec_t          dec;

   assign raw_flags[IDX_THR]  = vcc_lo_thr_i;
   assign raw_flags[IDX_BAK]  = vcc_lo_bak_i;
   assign raw_flags[IDX_DEEP] = vcc_deep_i;

   bkup_flag_sync #(
      .WIDTH  (NFLAG),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_flags),
      .q_o   (sync_flags)
   );

   for (genvar f = 0; f < NFLAG; f++) begin : g_filt
      bkup_flag_filter #(
         .STABLE_CYC (STABLE_CYC)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (sync_flags[f]),
         .filt_o (flt_q[f])
      );
   end

   bkup_sw_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .flt_i (flt_q),
      .dec_o (dec)
   );

   bkup_out_force #(
      .RST_ACT_HIGH (RST_ACT_HIGH)
   ) u_force (
      .bkup_i        (dec.bkup),
      .pfail_raw_n_i (pfail_raw_n_i),
      .rst_req_i     (rst_req_i),
      .pfail_n_o     (pfail_n_o),
      .rst_o         (rst_o),
      .wdog_dis_o    (wdog_dis_o),
      .pfi_dis_o     (pfi_dis_o)
   );

   assign main_sw_en_o = dec.main_en;
   assign bak_sw_en_o  = dec.bak_en;
   assign bkup_mode_o  = dec.bkup;
   assign cmp_off_o    = dec.deep;

endmodule

// File: rtl/bkup_sw_chk.sv
module bkup_sw_chk #(
   parameter bit RST_ACT_HIGH = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] flt_i,
   input logic       main_sw_en_o,
   input logic       bak_sw_en_o,
   input logic       bkup_mode_o,
   input logic       cmp_off_o,
   input logic       pfail_n_o,
   input logic       rst_o,
   input logic       wdog_dis_o,
   input logic       pfi_dis_o
);

   // R6: both paths never closed together
   p_excl_paths_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(main_sw_en_o && bak_sw_en_o));

   // R5: backup path closes only after a cycle with the main path open
   p_gap_to_bak_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bak_sw_en_o) |-> !$past(main_sw_en_o));

   // R5: main path closes only after a cycle with the backup path open
   p_gap_to_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_sw_en_o) |-> !$past(bak_sw_en_o));

   // R2: entry needs both filtered flags
   p_enter_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bak_sw_en_o) |-> $past(flt_i[0] && flt_i[1]));

   // R3: main path held while backup comparison is clear
   p_hold_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (main_sw_en_o && !flt_i[1]) |=> main_sw_en_o);

   // R4: leaving backup mode only on a cleared threshold flag
   p_leave_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bkup_mode_o) |-> !$past(flt_i[0]));

   // R7: forced levels during backup mode
   p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bkup_mode_o |-> (!pfail_n_o && wdog_dis_o && pfi_dis_o && (rst_o == RST_ACT_HIGH)));

   // R9: shutdown only inside backup mode
   p_deep_in_bkup_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_off_o |-> bkup_mode_o);

endmodule

bind bkup_sw_ctrl bkup_sw_chk #(
   .RST_ACT_HIGH (RST_ACT_HIGH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flt_i        (flt_q),
   .main_sw_en_o (main_sw_en_o),
   .bak_sw_en_o  (bak_sw_en_o),
   .bkup_mode_o  (bkup_mode_o),
   .cmp_off_o    (cmp_off_o),
   .pfail_n_o    (pfail_n_o),
   .rst_o        (rst_o),
   .wdog_dis_o   (wdog_dis_o),
   .pfi_dis_o    (pfi_dis_o)
);

// File: tb/sim_bkup_sw_ctrl.sv
`timescale 1ns/1ps
module sim_bkup_sw_ctrl;

   localparam int STB = 4;
   localparam int SYN = 2;
   localparam bit RHI = 1'b0;
   localparam int SETTLE = STB + SYN + 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic thr = 1'b0, bak = 1'b0, deep = 1'b0;
   logic pf_raw_n = 1'b1, rreq = 1'b0;
   logic main_en, bak_en, bmode, cmpoff, pf_n, rst_out, wdis, pdis;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bkup_sw_ctrl #(
      .STABLE_CYC   (STB),
      .SYNC_STAGES  (SYN),
      .RST_ACT_HIGH (RHI)
   ) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .vcc_lo_thr_i  (thr),
      .vcc_lo_bak_i  (bak),
      .vcc_deep_i    (deep),
      .pfail_raw_n_i (pf_raw_n),
      .rst_req_i     (rreq),
      .main_sw_en_o  (main_en),
      .bak_sw_en_o   (bak_en),
      .bkup_mode_o   (bmode),
      .cmp_off_o     (cmpoff),
      .pfail_n_o     (pf_n),
      .rst_o         (rst_out),
      .wdog_dis_o    (wdis),
      .pfi_dis_o     (pdis)
   );

   // behavioural reference: 0 main, 1 gap to backup, 2 backup, 3 shutdown, 4 gap to main
   int m_st;
   int m_flt [3];
   int m_run [3];
   int m_sy [SYN][3];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0;
         for (int i = 0; i < 3; i++) begin
            m_flt[i] = 0;
            m_run[i] = 0;
            for (int k = 0; k < SYN; k++) m_sy[k][i] = 0;
         end
      end else begin
         case (m_st)
            0: if (m_flt[0] == 1 && m_flt[1] == 1) m_st = 1;
            1: m_st = (m_flt[0] == 1 && m_flt[1] == 1) ? 2 : 0;
            2: if (m_flt[0] == 0) m_st = 4; else if (m_flt[2] == 1) m_st = 3;
            3: if (m_flt[0] == 0) m_st = 4; else if (m_flt[2] == 0) m_st = 2;
            default: m_st = 0;
         endcase
         for (int i = 0; i < 3; i++) begin
            if (m_sy[SYN-1][i] != m_flt[i]) begin
               if (m_run[i] == STB - 1) begin
                  m_flt[i] = m_sy[SYN-1][i];
                  m_run[i] = 0;
               end else begin
                  m_run[i]++;
               end
            end else begin
               m_run[i] = 0;
            end
         end
         for (int k = SYN - 1; k > 0; k--) begin
            for (int i = 0; i < 3; i++) m_sy[k][i] = m_sy[k-1][i];
         end
         m_sy[0][0] = int'(thr);
         m_sy[0][1] = int'(bak);
         m_sy[0][2] = int'(deep);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the model
   logic prev_main = 1'b1, prev_bak = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int e_bk, e_rst;
         e_bk  = (m_st == 2 || m_st == 3) ? 1 : 0;
         e_rst = (e_bk == 1 || rreq) ? 1 : 0;
         if (!RHI) e_rst = 1 - e_rst;
         chk(int'(main_en) == (m_st == 0 ? 1 : 0), "R2 main_sw_en", int'(main_en), (m_st == 0 ? 1 : 0));
         chk(int'(bak_en) == e_bk, "R2 bak_sw_en", int'(bak_en), e_bk);
         chk(int'(bmode) == e_bk, "R4 bkup_mode", int'(bmode), e_bk);
         chk(int'(cmpoff) == (m_st == 3 ? 1 : 0), "R9 cmp_off", int'(cmpoff), (m_st == 3 ? 1 : 0));
         chk(int'(pf_n) == (e_bk == 1 ? 0 : int'(pf_raw_n)), "R7 pfail_n", int'(pf_n), (e_bk == 1 ? 0 : int'(pf_raw_n)));
         chk(int'(rst_out) == e_rst, "R7 rst", int'(rst_out), e_rst);
         chk(int'(wdis) == e_bk && int'(pdis) == e_bk, "R7 disables", int'({wdis, pdis}), e_bk * 3);
         chk(!(main_en && bak_en), "R6 exclusive paths", int'({main_en, bak_en}), 0);
         chk(!(bak_en && !prev_bak && prev_main), "R5 dead cycle before backup", int'(prev_main), 0);
         chk(!(main_en && !prev_main && prev_bak), "R5 dead cycle before main", int'(prev_bak), 0);
         prev_main = main_en;
         prev_bak  = bak_en;
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         finish_run();
      end
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      // R1 reset state
      chk(main_en == 1'b1 && bak_en == 1'b0, "R1 paths after reset", int'({main_en, bak_en}), 2);
      chk(bmode == 1'b0 && cmpoff == 1'b0, "R1 mode after reset", int'({bmode, cmpoff}), 0);

      // R8 pass-through on main path
      pf_raw_n = 1'b0; rreq = 1'b1;
      wait_cyc(1);
      chk(pf_n == 1'b0 && rst_out == RHI, "R8 follow when low/asserted", int'({pf_n, rst_out}), int'({1'b0, RHI}));
      pf_raw_n = 1'b1; rreq = 1'b0;
      wait_cyc(1);
      chk(pf_n == 1'b1 && rst_out == !RHI && !wdis && !pdis, "R8 follow when idle", int'({pf_n, rst_out, wdis, pdis}), int'({1'b1, !RHI, 2'b00}));

      // R3 threshold low but backup comparison clear (grounded backup)
      thr = 1'b1; bak = 1'b0;
      wait_cyc(SETTLE);
      chk(main_en == 1'b1 && bak_en == 1'b0, "R3 stay on main", int'({main_en, bak_en}), 2);

      // R10 deep-drop flag while on main path
      deep = 1'b1;
      wait_cyc(SETTLE);
      chk(cmpoff == 1'b0 && main_en == 1'b1, "R10 deep ignored on main", int'({cmpoff, main_en}), 1);
      deep = 1'b0;
      wait_cyc(SETTLE);

      // R11 short pulse on backup comparison
      bak = 1'b1;
      wait_cyc(STB - 1);
      bak = 1'b0;
      wait_cyc(SETTLE);
      chk(main_en == 1'b1 && bak_en == 1'b0, "R11 glitch ignored", int'({main_en, bak_en}), 2);

      // R2 entry with both flags
      bak = 1'b1;
      wait_cyc(SETTLE);
      chk(bak_en == 1'b1 && main_en == 1'b0, "R2 entered backup", int'({main_en, bak_en}), 1);
      chk(pf_n == 1'b0 && rst_out == RHI && wdis && pdis, "R7 forced levels", int'({pf_n, rst_out, wdis, pdis}), int'({1'b0, RHI, 2'b11}));

      // R4 backup comparison clears, threshold still low
      bak = 1'b0;
      wait_cyc(SETTLE);
      chk(bmode == 1'b1, "R4 hold backup on threshold alone", int'(bmode), 1);

      // R9 deep drop in backup
      deep = 1'b1;
      wait_cyc(SETTLE);
      chk(cmpoff == 1'b1, "R9 shutdown on deep drop", int'(cmpoff), 1);

      // R12 backup comparison toggles during shutdown
      bak = 1'b1;
      wait_cyc(SETTLE);
      bak = 1'b0;
      wait_cyc(SETTLE);
      chk(cmpoff == 1'b1 && bmode == 1'b1, "R12 comparison ignored in shutdown", int'({cmpoff, bmode}), 3);

      deep = 1'b0;
      wait_cyc(SETTLE);
      chk(cmpoff == 1'b0 && bmode == 1'b1, "R9 shutdown released", int'({cmpoff, bmode}), 1);

      // R4 exit from shutdown with backup comparison still set
      deep = 1'b1; bak = 1'b1;
      wait_cyc(SETTLE);
      thr = 1'b0;
      wait_cyc(SETTLE);
      chk(main_en == 1'b1 && cmpoff == 1'b0 && bmode == 1'b0, "R4 return to main", int'({main_en, cmpoff, bmode}), 4);
      chk(pf_n == pf_raw_n && rst_out == !RHI, "R8 follow after return", int'({pf_n, rst_out}), int'({pf_raw_n, !RHI}));

      thr = 1'b0; bak = 1'b0; deep = 1'b0;
      wait_cyc(SETTLE);
      finish_run();
   end

endmodule